// File: doc/BRIEF.md
# Serial Audio Transmit Bit-Clock Generator

This block derives the transmit bit clock of a serial audio port from a fast master clock. An integer divider brings the master clock down to the bit rate. A source select picks either the divided clock or a bit clock supplied from outside. A polarity bit decides which bit-clock edge the transmitter shifts data on, and a routing bit decides whether the receive side borrows the transmit clock or keeps its own.

All sequential logic runs on the master clock. Besides the bit clock, the block emits a shift strobe: a one-cycle pulse in the master-clock domain that marks the chosen edge, so the data path can shift without a second clock domain. An external bit clock is first brought in through a synchronizer, and its edges are then detected. Software sets the block up through one 32-bit control word, written with a write enable and read back through a separate read port. No data streams through the block, so all of its pins are plain control and clock signals with no valid/ready handshake and no back-pressure.

Top module: `aud_bclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000_0060: shift on rising edge, separate receive clock, internal source, divide field 0.
- R2: Control bit 7 selects the shift edge, bit 6 selects receive routing, bit 5 selects the clock source and bits 4:0 hold the divide field. A write is visible on the read port one cycle later. Bits 31:8 always read zero and ignore writes.
- R3: With the internal source and divide field N from 1 to 31, the bit clock period is N+1 master cycles. It is high for floor((N+1)/2) cycles and low for the remainder, so on odd ratios the high phase is one cycle shorter.
- R4: With the internal source and N equal to 0, the bit clock is the master clock itself and the shift strobe is high on every cycle.
- R5: A new divide value takes effect at the terminal count of the running period, so the period in progress completes unchanged. A write that lands on the terminal-count edge applies to the period that begins at that edge.
- R6: With bit 7 at 0, the shift strobe is high exactly in the cycles where the bit clock has just risen. With bit 7 at 1, it is high exactly where the bit clock has just fallen.
- R7: With bit 5 at 0, the external bit-clock input passes through a two-flop synchronizer and one output register. A level applied before master edge k appears on the bit clock after edge k+2, and the strobe marks the selected edge in that same cycle.
- R8: With bit 6 at 0, the receive clock output equals the bit clock output. With bit 6 at 1, it equals the receive clock input.
- R9: For divide ratios of 2 or more, the shift strobe is one master cycle wide and occurs once per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock; clocks all logic |
| rst_n | input | 1 | Active-low reset, synchronous to clk_mst |
| reg_wr_en | input | 1 | Control word write enable |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| ext_bclk_i | input | 1 | External bit clock, asynchronous to clk_mst |
| rx_clk_i | input | 1 | Receive-side clock used when routing is separate |
| bclk_o | output | 1 | Transmit bit clock |
| shift_stb_o | output | 1 | One-cycle pulse at the selected bit-clock edge |
| rx_bclk_o | output | 1 | Clock delivered to the receive section |

## Verification
The divider's terminal count and a control-word write can both land on the same master edge. The block must then start the new period at the new ratio, without finishing one more period at the old ratio and without a runt. The bench finds a bit-clock rise, counts to the last cycle of the period, and aims the write at exactly that edge. It compares the sampled bit-clock levels with the old period followed directly by whole periods at the new ratio. A second run places the write early in a long period, where the old period has to complete before the new ratio is seen.

// File: rtl/aud_bclk_pkg.sv
`timescale 1ns/1ps
package aud_bclk_pkg;
  // Width of the divide field; ratio is field + 1.
  localparam int DIV_W    = 5;
  localparam int RATIO_W  = DIV_W + 1;
  localparam int REG_W    = 32;
  localparam int CFG_W    = DIV_W + 3;

  // Field order matches the control-word bit positions 7..0.
  typedef struct packed {
    logic             shift_fall;  // 1: shift on falling bit-clock edge
    logic             rx_split;    // 1: receive side uses its own clock
    logic             src_int;     // 1: internal divider, 0: external pin
    logic [DIV_W-1:0] div;         // divide ratio minus one
  } bclk_cfg_t;

  localparam bclk_cfg_t CFG_RST = '{shift_fall: 1'b0, rx_split: 1'b1,
                                    src_int: 1'b1, div: '0};
endpackage

// File: rtl/aud_bclk_cfg_reg.sv
`timescale 1ns/1ps
module aud_bclk_cfg_reg
  import aud_bclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output bclk_cfg_t        cfg_q,
  output bclk_cfg_t        cfg_nxt,
  output logic [REG_W-1:0] rdata
);
  localparam int RSVD_W = REG_W - CFG_W;

  // Reserved write bits are dropped on purpose.
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[REG_W-1:CFG_W];

  // Write-through view lets the divider pick up a value written on
  // the very edge of its terminal count.
  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_en) cfg_nxt = bclk_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_nxt;
  end

  assign rdata = {{RSVD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/aud_bclk_div.sv
`timescale 1ns/1ps
module aud_bclk_div
  import aud_bclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_nxt,
  output logic             lvl_nxt,
  output logic             bypass_nxt,
  output logic             bypass_q
);
  logic [RATIO_W-1:0] cnt_q, cnt_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n;
  logic               term;

  // The active ratio is reloaded only at terminal count.
  always_comb begin
    term    = (cnt_q == ratio_q - RATIO_W'(1));
    ratio_n = ratio_q;
    cnt_n   = cnt_q + RATIO_W'(1);
    if (term) begin
      ratio_n = RATIO_W'(div_nxt) + RATIO_W'(1);
      cnt_n   = '0;
    end
  end

  // High for the first floor(ratio/2) counts of each period.
  assign lvl_nxt    = (cnt_n < (ratio_n >> 1));
  assign bypass_nxt = (ratio_n == RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ratio_q  <= RATIO_W'(1);
      bypass_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_n;
      ratio_q  <= ratio_n;
      bypass_q <= bypass_nxt;
    end
  end
endmodule

// File: rtl/aud_bclk_edge.sv
`timescale 1ns/1ps
module aud_bclk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_int,
  input  logic shift_fall,
  input  logic div_lvl_nxt,
  input  logic div_bypass_nxt,
  output logic bclk_q,
  output logic stb_q
);
  logic [SYNC_STAGES-1:0] sync_q;

  // Synchronizer chain for the asynchronous external bit clock.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic d;
    if (g == 0) begin : g_first
      assign d = ext_clk;
    end else begin : g_next
      assign d = sync_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= d;
    end
  end

  logic lvl_nxt, stb_nxt;

  always_comb begin
    lvl_nxt = src_int ? div_lvl_nxt : sync_q[SYNC_STAGES-1];
    if (src_int && div_bypass_nxt) stb_nxt = 1'b1;
    else if (shift_fall)           stb_nxt = bclk_q & ~lvl_nxt;
    else                           stb_nxt = ~bclk_q & lvl_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      bclk_q <= lvl_nxt;
      stb_q  <= stb_nxt;
    end
  end
endmodule

// File: rtl/aud_bclk_gen.sv
`timescale 1ns/1ps
module aud_bclk_gen
  import aud_bclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_mst,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_bclk_i,
  input  logic        rx_clk_i,
  output logic        bclk_o,
  output logic        shift_stb_o,
  output logic        rx_bclk_o
);
  bclk_cfg_t cfg_q, cfg_nxt;
  logic      div_lvl_nxt, div_bypass_nxt, div_bypass_q;
  logic      bclk_q;

  aud_bclk_cfg_reg i_cfg (
    .clk     (clk_mst),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wdata   (reg_wdata),
    .cfg_q   (cfg_q),
    .cfg_nxt (cfg_nxt),
    .rdata   (reg_rdata)
  );

  aud_bclk_div i_div (
    .clk        (clk_mst),
    .rst_n      (rst_n),
    .div_nxt    (cfg_nxt.div),
    .lvl_nxt    (div_lvl_nxt),
    .bypass_nxt (div_bypass_nxt),
    .bypass_q   (div_bypass_q)
  );

  aud_bclk_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk            (clk_mst),
    .rst_n          (rst_n),
    .ext_clk        (ext_bclk_i),
    .src_int        (cfg_q.src_int),
    .shift_fall     (cfg_q.shift_fall),
    .div_lvl_nxt    (div_lvl_nxt),
    .div_bypass_nxt (div_bypass_nxt),
    .bclk_q         (bclk_q),
    .stb_q          (shift_stb_o)
  );

  // Divide-by-1 hands the master clock straight through.
  assign bclk_o    = (cfg_q.src_int && div_bypass_q) ? clk_mst : bclk_q;
  assign rx_bclk_o = cfg_q.rx_split ? rx_clk_i : bclk_o;
endmodule

// File: rtl/aud_bclk_gen_chk.sv
`timescale 1ns/1ps
module aud_bclk_gen_chk (
  input logic        clk_mst,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [7:0]  wr_low,
  input logic [31:0] reg_rdata,
  input logic        ext_bclk_i,
  input logic        bclk_o,
  input logic        shift_stb_o
);
  // Cycles since the last control write (saturating).
  logic [6:0] quiet_q;
  always_ff @(posedge clk_mst) begin
    if (!rst_n)              quiet_q <= '0;
    else if (reg_wr_en)      quiet_q <= '0;
    else if (quiet_q != 7'h7f) quiet_q <= quiet_q + 7'd1;
  end

  logic pol, src, div0;
  assign pol  = reg_rdata[7];
  assign src  = reg_rdata[5];
  assign div0 = (reg_rdata[4:0] == 5'd0);

  a_r2_readback: assert property (@(posedge clk_mst) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata == {24'd0, $past(wr_low)});

  a_r6_rise_strobe: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (shift_stb_o && !pol && !(src && div0) && $stable(reg_rdata) && quiet_q >= 7'd2)
      |-> $rose(bclk_o));

  a_r6_fall_strobe: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (shift_stb_o && pol && !(src && div0) && $stable(reg_rdata) && quiet_q >= 7'd2)
      |-> $fell(bclk_o));

  a_r4_bypass_strobe: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (src && div0 && quiet_q >= 7'd34) |-> shift_stb_o);

  a_r7_ext_latency: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (!src && quiet_q >= 7'd3) |-> bclk_o == $past(ext_bclk_i, 3));

  a_r9_single_pulse: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (src && !div0 && quiet_q >= 7'd34 && shift_stb_o) |=> !shift_stb_o);
endmodule

bind aud_bclk_gen aud_bclk_gen_chk i_chk (
  .clk_mst     (clk_mst),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .wr_low      (reg_wdata[7:0]),
  .reg_rdata   (reg_rdata),
  .ext_bclk_i  (ext_bclk_i),
  .bclk_o      (bclk_o),
  .shift_stb_o (shift_stb_o)
);

// File: tb/test_aud_bclk_gen.sv
`timescale 1ns/1ps
module test_aud_bclk_gen;
  logic        clk_mst = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_bclk_i = 1'b0;
  logic        rx_clk_i = 1'b0;
  logic        bclk_o, shift_stb_o, rx_bclk_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_mst = ~clk_mst;  // 50 MHz

  aud_bclk_gen i_aud_bclk_gen (
    .clk_mst(clk_mst), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_bclk_i(ext_bclk_i),
    .rx_clk_i(rx_clk_i), .bclk_o(bclk_o), .shift_stb_o(shift_stb_o),
    .rx_bclk_o(rx_bclk_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk_mst);
    reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk_mst);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] cfg_word(input bit pol, input bit split,
                                           input bit src, input int n);
    return {24'd0, pol, split, src, n[4:0]};
  endfunction

  // R1, R4, R8: reset state and divide-by-1 pass-through
  task automatic t_reset();
    @(negedge clk_mst);
    check(reg_rdata == 32'h60, "R1", "reset control word", reg_rdata, 32'h60);
    repeat (3) @(negedge clk_mst);
    check(shift_stb_o == 1'b1, "R4", "strobe every cycle at div1", shift_stb_o, 1);
    check(bclk_o == 1'b0, "R4", "bclk low in master low phase", bclk_o, 0);
    @(posedge clk_mst); #2;
    check(bclk_o == 1'b1, "R4", "bclk high in master high phase", bclk_o, 1);
    @(negedge clk_mst);
    check(shift_stb_o == 1'b1, "R4", "strobe still high next cycle", shift_stb_o, 1);
    rx_clk_i = 1'b1; #1;
    check(rx_bclk_o == 1'b1, "R8", "separate rx clock follows input", rx_bclk_o, 1);
    rx_clk_i = 1'b0; #1;
    check(rx_bclk_o == 1'b0, "R8", "separate rx clock follows input low", rx_bclk_o, 0);
  endtask

  // R2: field readback and reserved bits
  task automatic t_reg();
    wr_cfg(32'hFFFF_FFFF);
    check(reg_rdata == 32'hFF, "R2", "all-ones write readback", reg_rdata, 32'hFF);
    wr_cfg(32'hFFFF_FF00);
    check(reg_rdata == 32'h0, "R2", "reserved-only write readback", reg_rdata, 0);
    wr_cfg(32'h0000_00A5);
    check(reg_rdata == 32'hA5, "R2", "mixed field readback", reg_rdata, 32'hA5);
  endtask

  // R3, R6, R9: period shape and strobe placement
  task automatic t_ratio(input int n, input bit pol);
    int r = n + 1;
    int hi_exp = r / 2;
    int hi = 0, lo = 0, bad = 0, nstb = 0;
    bit prev, cur, found;
    wr_cfg(cfg_word(pol, 1'b1, 1'b1, n));
    repeat (40) @(negedge clk_mst);
    prev = bclk_o; found = 0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk_mst); cur = bclk_o;
      if (!prev && cur) found = 1;
      prev = cur;
    end
    check(found, "R3", "bit clock rise seen", found, 1);
    hi = 1;
    for (int i = 1; i <= 2 * r; i++) begin
      @(negedge clk_mst); cur = bclk_o;
      if (i < r) begin
        if (cur && lo == 0) hi++;
        else lo++;
      end
      if (shift_stb_o != (pol ? (prev && !cur) : (!prev && cur))) bad++;
      if (shift_stb_o) nstb++;
      prev = cur;
    end
    check(hi == hi_exp, "R3", $sformatf("high cycles ratio %0d", r), hi, hi_exp);
    check(lo == r - hi_exp, "R3", $sformatf("low cycles ratio %0d", r), lo, r - hi_exp);
    check(bad == 0, "R6", $sformatf("strobe placement pol %0d ratio %0d", pol, r), bad, 0);
    check(nstb == 2, "R9", $sformatf("one strobe per period ratio %0d", r), nstb, 2);
  endtask

  // R5: divide change timing relative to terminal count
  task automatic t_switch(input int n_old, input int n_new, input int wr_idx);
    int ro = n_old + 1, rn = n_new + 1;
    int bad = 0;
    bit prev, cur, found, exp;
    wr_cfg(cfg_word(1'b0, 1'b1, 1'b1, n_old));
    repeat (40) @(negedge clk_mst);
    prev = bclk_o; found = 0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk_mst); cur = bclk_o;
      if (!prev && cur) found = 1;
      prev = cur;
    end
    for (int i = 0; i < ro + 3 * rn; i++) begin
      if (i > 0) begin @(negedge clk_mst); cur = bclk_o; end
      if (i < ro) exp = (i < ro / 2);
      else        exp = (((i - ro) % rn) < rn / 2);
      if (cur != exp) bad++;
      if (i == wr_idx) begin
        reg_wr_en = 1'b1; reg_wdata = cfg_word(1'b0, 1'b1, 1'b1, n_new);
      end else if (i == wr_idx + 1) begin
        reg_wr_en = 1'b0; reg_wdata = '0;
      end
    end
    check(found && bad == 0, "R5",
          $sformatf("switch %0d->%0d write at count %0d mismatches", ro, rn, wr_idx),
          bad, 0);
  endtask

  // R7: external source latency and strobe
  task automatic t_ext(input bit pol);
    bit lvl = pol ? 1'b0 : 1'b1;
    wr_cfg(cfg_word(pol, 1'b1, 1'b0, 3));
    ext_bclk_i = ~lvl;
    repeat (6) @(negedge clk_mst);
    ext_bclk_i = lvl;
    repeat (2) @(negedge clk_mst);
    check(bclk_o == ~lvl, "R7", "old level two edges after change", bclk_o, ~lvl);
    @(negedge clk_mst);
    check(bclk_o == lvl, "R7", "new level three edges after change", bclk_o, lvl);
    check(shift_stb_o == 1'b1, "R7", $sformatf("strobe on selected edge pol %0d", pol),
          shift_stb_o, 1);
    @(negedge clk_mst);
    check(shift_stb_o == 1'b0, "R7", "strobe one cycle wide", shift_stb_o, 0);
    ext_bclk_i = ~lvl;
    repeat (3) @(negedge clk_mst);
    check(shift_stb_o == 1'b0, "R6", "no strobe on unselected edge", shift_stb_o, 0);
  endtask

  // R8: shared receive clock
  task automatic t_rx_shared();
    int bad = 0;
    wr_cfg(cfg_word(1'b0, 1'b0, 1'b1, 3));
    rx_clk_i = 1'b1;
    repeat (20) @(negedge clk_mst);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_mst);
      if (rx_bclk_o != bclk_o) bad++;
    end
    check(bad == 0, "R8", "shared rx clock equals bit clock", bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_mst);
    rst_n = 1'b1;
    t_reset();
    t_reg();
    t_ratio(1, 1'b0);
    t_ratio(4, 1'b0);
    t_ratio(7, 1'b0);
    t_ratio(31, 1'b0);
    t_ratio(2, 1'b1);
    t_ratio(5, 1'b1);
    t_switch(7, 1, 0);
    t_switch(3, 5, 3);
    t_ext(1'b0);
    t_ext(1'b1);
    t_rx_shared();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule